// File: doc/BRIEF.md
# Bang-Bang Proportional-Integral Loop Filter

This block is the digital controller of a divider-free, integer-N all-digital PLL. On every rising edge of the reference clock it takes the one-bit early/late decision of a bang-bang phase detector and treats it as a signed error of +1 or -1. There is no zero error value. It then applies a proportional-integral control law and produces an unsigned oscillator tuning code for a 10-bit capacitive DAC.

The error is only a sign, so each coefficient product reduces to adding or subtracting a constant. The integrator keeps `FRAC_W` fractional bits below the DAC resolution. The proportional path adds a signed offset on top of the integrator, and the sum is rounded to the DAC width. Both the integrator and the output saturate instead of wrapping.

The synchronous reset loads a programmable mid-scale value so the loop can restart from a known code. The `enable` input freezes the whole loop while the PLL sleeps. Seen from outside, the law is y[n] = y[n-1] + (KP+KI)·x[n] − KP·x[n-1], a direct form I difference equation, as long as no saturation occurs.

Top module: `bbpi_loop_filter`

## Requirements
- R1: When `rst` is high at a rising edge, the integrator loads RESET_CODE·2^FRAC_W, and `tuneCode` equals RESET_CODE (512 by default) after that edge.
- R2: `late`=1 is taken as error +1 and `late`=0 as error −1. No input value gives a zero error.
- R3: At each enabled edge without reset, the integrator changes by +KI when the error is +1 and by −KI when it is −1. KI is in units of 2^-FRAC_W of one output code (default KI=1, FRAC_W=6).
- R4: After each enabled edge, `tuneCode` equals floor((S + 2^(FRAC_W-1)) / 2^FRAC_W), where S is the new integrator value plus KP·error (default KP=16). The result is registered, so it appears after the same edge.
- R5: The integrator saturates at 0 and at (2^OUT_W−1)·2^FRAC_W and never wraps.
- R6: The sum S is clamped to the same range before rounding, so `tuneCode` stays pinned at 0 or 1023 and never wraps.
- R7: While `enable` is low and `rst` is low, both the integrator and `tuneCode` hold their values, whatever `late` does.
- R8: When `enable` returns high, accumulation continues from the frozen integrator value. No reload takes place.
- R9: `rst` takes priority over `enable` and over `late`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one decision is taken per rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the mid-scale value |
| enable | input | 1 | High: loop runs; low: integrator and output frozen |
| late | input | 1 | Phase detector decision: 1 = feedback edge late (+1), 0 = early (−1) |
| tuneCode | output | OUT_W (10) | Unsigned oscillator tuning code for the DAC |

## Verification
A wrong integrator value never shows directly at the ports. It shows up in `tuneCode` as soon as enough error of one sign has accumulated to cross a rounding boundary. A corrupted proportional term or a wrong rounding point shows after the very next edge, as a step of the wrong size or direction. The reference model is therefore compared against `tuneCode` after every edge, so a divergence is reported in the cycle it first becomes visible. Long one-sided runs drive the integrator into both saturation limits, where wrap-around would show up at once as a jump across the full code range.

// File: rtl/bbpi_pkg.sv
package bbpi_pkg;

  // Strobes from control to datapath, valid for one reference cycle.
  typedef struct packed {
    logic load;   // load integrator and output with the mid-scale value
    logic step;   // run one PI update this cycle
    logic dirUp;  // sign of the error: 1 means +1, 0 means -1
  } lfStrobe_t;

endpackage

// File: rtl/bbpi_ctrl.sv
module bbpi_ctrl
  import bbpi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      late,
  output lfStrobe_t strobe
);

  // Reset wins over enable; the decision bit becomes the error sign.
  always_comb begin
    strobe.load  = rst;
    strobe.step  = !rst && enable;
    strobe.dirUp = late;
  end

  // R9
  reset_priority_chk: assert property (@(posedge clk)
    rst |-> (strobe.load && !strobe.step));

  // R7
  sleep_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !strobe.step);

endmodule

// File: rtl/bbpi_datapath.sv
module bbpi_datapath
  import bbpi_pkg::*;
#(
  parameter int OUT_W      = 10,
  parameter int FRAC_W     = 6,
  parameter int KP         = 16,
  parameter int KI         = 1,
  parameter int RESET_CODE = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  lfStrobe_t        strobe,
  output logic [OUT_W-1:0] tuneCode
);

  localparam int ACC_W  = OUT_W + FRAC_W + 2;
  localparam int MAXFIX = ((1 << OUT_W) - 1) << FRAC_W;
  localparam int HALF   = 1 << (FRAC_W - 1);

  typedef logic signed [ACC_W-1:0] fix_t;

  localparam fix_t MAX_S   = fix_t'(MAXFIX);
  localparam fix_t KP_S    = fix_t'(KP);
  localparam fix_t KI_S    = fix_t'(KI);
  localparam fix_t HALF_S  = fix_t'(HALF);
  localparam fix_t INIT_S  = fix_t'(RESET_CODE << FRAC_W);

  function automatic fix_t clampFix(input fix_t v);
    if (v < 0)          return '0;
    else if (v > MAX_S) return MAX_S;
    else                return v;
  endfunction

  fix_t integQ, integNext, propSum, roundSum;
  logic [OUT_W-1:0] codeQ, codeNext;

  // Integral path: add or subtract KI, then saturate.
  always_comb begin
    integNext = clampFix(strobe.dirUp ? (integQ + KI_S) : (integQ - KI_S));
    propSum   = clampFix(strobe.dirUp ? (integNext + KP_S) : (integNext - KP_S));
    roundSum  = propSum + HALF_S;
    codeNext  = roundSum[FRAC_W +: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      integQ <= INIT_S;
      codeQ  <= OUT_W'(RESET_CODE);
    end else if (strobe.step) begin
      integQ <= integNext;
      codeQ  <= codeNext;
    end
  end

  assign tuneCode = codeQ;

  // R5
  integ_range_chk: assert property (@(posedge clk) disable iff (rst)
    (integQ >= 0) && (integQ <= MAX_S));

  // R3
  integ_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && strobe.dirUp && (integQ <= MAX_S - KI_S))
      |=> (integQ > $past(integQ)));

  // R3
  integ_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.dirUp && (integQ >= KI_S))
      |=> (integQ < $past(integQ)));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.step) |=> ($stable(codeQ) && $stable(integQ)));

  // R1
  reset_code_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe.load) |-> (codeQ == OUT_W'(RESET_CODE)));

endmodule

// File: rtl/bbpi_loop_filter.sv
module bbpi_loop_filter
  import bbpi_pkg::*;
#(
  parameter int OUT_W      = 10,
  parameter int FRAC_W     = 6,
  parameter int KP         = 16,
  parameter int KI         = 1,
  parameter int RESET_CODE = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             late,
  output logic [OUT_W-1:0] tuneCode
);

  lfStrobe_t strobe;

  bbpi_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .late   (late),
    .strobe (strobe)
  );

  bbpi_datapath #(
    .OUT_W      (OUT_W),
    .FRAC_W     (FRAC_W),
    .KP         (KP),
    .KI         (KI),
    .RESET_CODE (RESET_CODE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .tuneCode (tuneCode)
  );

endmodule

// File: tb/tb_bbpi_loop_filter.sv
module tb_bbpi_loop_filter;

  localparam int OUT_W  = 10;
  localparam int FRAC_W = 6;
  localparam int KP     = 16;
  localparam int KI     = 1;
  localparam int RCODE  = 512;
  localparam int MAXF   = ((1 << OUT_W) - 1) << FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic late = 1'b0;
  logic [OUT_W-1:0] tuneCode;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mInteg = 0;
  int mCode = 0;

  always #2.5 clk = ~clk;

  bbpi_loop_filter #(
    .OUT_W(OUT_W), .FRAC_W(FRAC_W), .KP(KP), .KI(KI), .RESET_CODE(RCODE)
  ) dut (
    .clk(clk), .rst(rst), .enable(enable), .late(late), .tuneCode(tuneCode)
  );

  function automatic int clampI(input int v);
    if (v < 0) return 0;
    if (v > MAXF) return MAXF;
    return v;
  endfunction

  task automatic checkCode(input int exp);
    checks++;
    if (int'(tuneCode) != exp) begin
      fails++;
      $display("FAIL %s: tuneCode=%0d expected=%0d at %0t", curReq, tuneCode, exp, $time);
    end
  endtask

  // Drive at a falling edge, update the model, compare at the next falling edge.
  task automatic cyc(input bit r, input bit e, input bit l);
    int s;
    rst = r; enable = e; late = l;
    if (r) begin
      mInteg = RCODE << FRAC_W;
      mCode  = RCODE;
    end else if (e) begin
      mInteg = clampI(mInteg + (l ? KI : -KI));
      s      = clampI(mInteg + (l ? KP : -KP));
      mCode  = (s + (1 << (FRAC_W - 1))) >> FRAC_W;
    end
    @(negedge clk);
    checkCode(mCode);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    curReq = "R1";
    cyc(1, 0, 0);
    cyc(1, 1, 1);
    checkCode(512);

    // R2 / R4: single late then single early
    curReq = "R2";
    cyc(0, 1, 1);   // integ 32769, sum 32785 -> 512
    checkCode(512);
    cyc(0, 1, 0);   // integ 32768, sum 32752 -> 512
    checkCode(512);

    // R3 / R4: sustained late pushes across rounding points
    curReq = "R3";
    for (int i = 0; i < 200; i++) cyc(0, 1, 1);
    curReq = "R4";
    for (int i = 0; i < 64; i++) cyc(0, 1, (i % 3) != 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, i[0]);

    // R7: sleep with toggling decisions
    curReq = "R7";
    begin
      int held;
      held = mCode;
      for (int i = 0; i < 40; i++) cyc(0, 0, i[1]);
      checkCode(held);
    end

    // R8: resume from frozen integrator
    curReq = "R8";
    for (int i = 0; i < 100; i++) cyc(0, 1, 0);

    // R9: reset while enabled and late
    curReq = "R9";
    cyc(1, 1, 1);
    checkCode(512);

    // R5 / R6: drive to the upper limit and hold there
    curReq = "R5";
    for (int i = 0; i < 33000; i++) cyc(0, 1, 1);
    curReq = "R6";
    checkCode(1023);
    for (int i = 0; i < 20; i++) cyc(0, 1, 1);
    checkCode(1023);
    // one early step off the limit: integ MAXF-1, sum MAXF-17 -> 1023
    cyc(0, 1, 0);

    // R5 / R6: drive to the lower limit and hold there
    curReq = "R5";
    for (int i = 0; i < 66000; i++) cyc(0, 1, 0);
    curReq = "R6";
    checkCode(0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 0);
    checkCode(0);
    // integ 1, sum 17 -> (17+32)>>6 = 0
    cyc(0, 1, 1);
    checkCode(0);
    // integ 2, sum 18 -> 0; more late steps walk up from the floor
    for (int i = 0; i < 40; i++) cyc(0, 1, 1);

    // R1: reset again restores mid-scale
    curReq = "R1";
    cyc(1, 0, 1);
    checkCode(512);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule